// File: doc/BRIEF.md
# Asymmetric-width dual-port RAM

This block is a synchronous memory with two fully independent ports that look at one shared store through different word widths. The narrow port sees 1024 words of 13 bits. The wide port sees 512 words of 26 bits. Each port has its own clock, synchronous reset, enable, write enable, address, write data and registered read data. Either port can read or write at any time.

Each wide word is built from two narrow words placed side by side. The even narrow address fills the low half and the odd narrow address fills the high half. The ports never repack data across word boundaries. A typical use is rate conversion: a fast producer writes 13-bit words on the narrow port, and a consumer reads 26-bit words on the wide port at half the rate.

The store is split into two banks, one written only by each port. The value a port sees is the XOR of the two banks. Each bank therefore has a single writer and a single clock. The lane width, the width ratio and the row count are parameters. The ratio must be a power of two of at least 2. The `SAME_CLK` parameter enables the cross-port checks that only make sense when both ports share one clock.

Top module: `asym_dpram`

## Requirements
- R1: The narrow port (1024 x 13 bits) and the wide port (512 x 26 bits) address one shared store of 13312 bits. Data written through either port is read back through the other.
- R2: Narrow address 2k corresponds to bits [12:0] of wide word k. Narrow address 2k+1 corresponds to bits [25:13] of wide word k.
- R3: A wide-port write replaces all 26 bits of the addressed wide word.
- R4: A narrow-port write changes only its own 13-bit half of a wide word. The other half keeps its contents.
- R5: Read data is registered. It shows the addressed contents after the rising edge at which the port's enable is sampled high, one cycle after the address.
- R6: Reads are read-first. When a location is written and read in the same cycle, the read returns the contents from before the write. This holds whether the write comes from the same port or from the other port.
- R7: A port's read data holds its value on every cycle in which that port's enable is low.
- R8: While a port's enable is low, its write enable, address and write data have no effect on the store.
- R9: A port's synchronous active-high reset clears only that port's read data to zero. Reset leaves the store untouched. The store starts at all zeros.
- R10: The two ports may write in the same cycle. Writes to bits that do not overlap both take effect. If the writes overlap, the result for the overlapping bits is undefined. With `SAME_CLK` set, a check flags any overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| n_clk | input | 1 | Narrow-port clock |
| n_rst | input | 1 | Narrow-port synchronous reset of read data, active high |
| n_en | input | 1 | Narrow-port enable |
| n_we | input | 1 | Narrow-port write enable (used only when `n_en` is high) |
| n_addr | input | 10 | Narrow word address |
| n_wdata | input | 13 | Narrow write data |
| n_rdata | output | 13 | Narrow registered read data |
| w_clk | input | 1 | Wide-port clock |
| w_rst | input | 1 | Wide-port synchronous reset of read data, active high |
| w_en | input | 1 | Wide-port enable |
| w_we | input | 1 | Wide-port write enable (used only when `w_en` is high) |
| w_addr | input | 9 | Wide word address |
| w_wdata | input | 26 | Wide write data |
| w_rdata | output | 26 | Wide registered read data |

## Verification
Two kinds of event can land on the same clock edge:
- one port writes a row while the other port reads that same row;
- both ports write, to different rows.

The bench runs both ports on one clock. Its driver issues the two port operations in a single call, which is how it provokes these cases.

The reference model judges each cycle in two steps. It takes every read expectation from its contents before the cycle. Only then does it apply the writes.

A read that returns the new data, or a disjoint write that is lost, is therefore reported as a mismatch against the model.

// File: rtl/adp_pkg.sv
package adp_pkg;

    // Default geometry: 13-bit lanes, two lanes per wide word, 512 rows.
    localparam int unsigned DEF_LANE_W = 13;
    localparam int unsigned DEF_RATIO  = 2;
    localparam int unsigned DEF_ROWS   = 512;
    localparam int unsigned MAX_RATIO  = 16;

    typedef logic [MAX_RATIO-1:0] lane_set_t;

    // Lane mask with `count` ones starting at lane `first`.
    function automatic lane_set_t lane_span(input int unsigned count, input int unsigned first);
        lane_set_t ones;
        ones = (lane_set_t'(1) << count) - lane_set_t'(1);
        return ones << first;
    endfunction

    // Number of address bits needed to pick one of n groups (0 when n is 1).
    function automatic int unsigned sel_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

endpackage

// File: rtl/adp_bank.sv
// One storage bank with a single writer. Stored lanes hold write data XOR
// the other bank, so the XOR of both banks gives the visible contents.
module adp_bank
    import adp_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned RATIO  = DEF_RATIO,
    parameter int unsigned ROWS   = DEF_ROWS,
    localparam int unsigned WW    = LANE_W * RATIO,
    localparam int unsigned RAW   = $clog2(ROWS)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [RAW-1:0] row,
    input  logic [RATIO-1:0] mask,
    input  logic [WW-1:0]  wvec,
    input  logic [WW-1:0]  far_word,
    input  logic [RAW-1:0] peek_row,
    output logic [WW-1:0]  own_word,
    output logic [WW-1:0]  peek_word
);

    logic [WW-1:0] mem [ROWS] = '{default: '0};

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < int'(RATIO); l++) begin
                if (mask[l]) begin
                    mem[row][l*LANE_W +: LANE_W] <= wvec[l*LANE_W +: LANE_W]
                                                  ^ far_word[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign own_word  = mem[row];
    assign peek_word = mem[peek_row];

endmodule

// File: rtl/adp_port.sv
// Per-port front end. It splits the address into row and lane group,
// spreads the write data over the lanes, and registers the read slice.
module adp_port
    import adp_pkg::*;
#(
    parameter int unsigned LANE_W     = DEF_LANE_W,
    parameter int unsigned RATIO      = DEF_RATIO,
    parameter int unsigned ROWS       = DEF_ROWS,
    parameter int unsigned PORT_LANES = 1,
    localparam int unsigned WW        = LANE_W * RATIO,
    localparam int unsigned PW        = LANE_W * PORT_LANES,
    localparam int unsigned GROUPS    = RATIO / PORT_LANES,
    localparam int unsigned GSB       = sel_bits(GROUPS),
    localparam int unsigned RAW       = $clog2(ROWS),
    localparam int unsigned AW        = RAW + GSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [PW-1:0]    wdata,
    input  logic [WW-1:0]    word,
    output logic             wr,
    output logic [RAW-1:0]   row,
    output logic [RATIO-1:0] mask,
    output logic [WW-1:0]    wvec,
    output logic [PW-1:0]    rdata
);

    int unsigned grp;

    generate
        if (GSB > 0) begin : g_split
            assign row = addr[AW-1:GSB];
            always_comb grp = 32'(addr[GSB-1:0]);
        end else begin : g_whole
            assign row = addr;
            assign grp = 0;
        end
    endgenerate

    assign wr   = en & we;
    assign mask = RATIO'(lane_span(PORT_LANES, grp * PORT_LANES));
    assign wvec = {GROUPS{wdata}};

    // Read-first: the slice of the contents before this edge is captured.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (en) begin
            rdata <= PW'(word >> (grp * PW));
        end
    end

    // R7: disabled port keeps its read data
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(rdata));

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
    import adp_pkg::*;
#(
    parameter int unsigned LANE_W   = DEF_LANE_W,
    parameter int unsigned RATIO    = DEF_RATIO,
    parameter int unsigned ROWS     = DEF_ROWS,
    parameter bit          SAME_CLK = 1'b0,
    localparam int unsigned WW      = LANE_W * RATIO,
    localparam int unsigned RAW     = $clog2(ROWS),
    localparam int unsigned NAW     = RAW + sel_bits(RATIO)
) (
    input  logic              n_clk,
    input  logic              n_rst,
    input  logic              n_en,
    input  logic              n_we,
    input  logic [NAW-1:0]    n_addr,
    input  logic [LANE_W-1:0] n_wdata,
    output logic [LANE_W-1:0] n_rdata,
    input  logic              w_clk,
    input  logic              w_rst,
    input  logic              w_en,
    input  logic              w_we,
    input  logic [RAW-1:0]    w_addr,
    input  logic [WW-1:0]     w_wdata,
    output logic [WW-1:0]     w_rdata
);

    logic             n_wr, w_wr;
    logic [RAW-1:0]   n_row, w_row;
    logic [RATIO-1:0] n_mask, w_mask;
    logic [WW-1:0]    n_wvec, w_wvec;
    logic [WW-1:0]    nb_own, nb_peek, wb_own, wb_peek;
    logic [WW-1:0]    n_word, w_word;

    // Visible contents are the XOR of both banks at the row.
    assign n_word = nb_own ^ wb_peek;
    assign w_word = wb_own ^ nb_peek;

    adp_port #(.LANE_W(LANE_W), .RATIO(RATIO), .ROWS(ROWS), .PORT_LANES(1)) u_nport (
        .clk(n_clk), .rst(n_rst), .en(n_en), .we(n_we), .addr(n_addr), .wdata(n_wdata),
        .word(n_word), .wr(n_wr), .row(n_row), .mask(n_mask), .wvec(n_wvec), .rdata(n_rdata));

    adp_port #(.LANE_W(LANE_W), .RATIO(RATIO), .ROWS(ROWS), .PORT_LANES(RATIO)) u_wport (
        .clk(w_clk), .rst(w_rst), .en(w_en), .we(w_we), .addr(w_addr), .wdata(w_wdata),
        .word(w_word), .wr(w_wr), .row(w_row), .mask(w_mask), .wvec(w_wvec), .rdata(w_rdata));

    adp_bank #(.LANE_W(LANE_W), .RATIO(RATIO), .ROWS(ROWS)) u_nbank (
        .clk(n_clk), .we(n_wr), .row(n_row), .mask(n_mask), .wvec(n_wvec),
        .far_word(wb_peek), .peek_row(w_row), .own_word(nb_own), .peek_word(nb_peek));

    adp_bank #(.LANE_W(LANE_W), .RATIO(RATIO), .ROWS(ROWS)) u_wbank (
        .clk(w_clk), .we(w_wr), .row(w_row), .mask(w_mask), .wvec(w_wvec),
        .far_word(nb_peek), .peek_row(n_row), .own_word(wb_own), .peek_word(wb_peek));

    generate
        if (SAME_CLK) begin : g_sync_checks
            logic [WW-1:0] n_bits;
            always_comb begin
                for (int l = 0; l < int'(RATIO); l++) begin
                    n_bits[l*LANE_W +: LANE_W] = {LANE_W{n_mask[l]}};
                end
            end

            // R10: overlapping writes in one cycle are not allowed
            p_no_write_clash_r10: assert property (@(posedge n_clk) disable iff (n_rst || w_rst)
                !(n_wr && w_wr && (n_row == w_row) && |(n_mask & w_mask)));

            // R2: a wide write is seen in the matching narrow lane
            p_wide_to_narrow_r2: assert property (@(posedge n_clk) disable iff (n_rst || w_rst)
                ($past(w_wr) && n_en && !n_we && (n_row == $past(w_row)))
                |=> (({RATIO{n_rdata}} & $past(n_bits)) == ($past(w_wvec, 2) & $past(n_bits))));

            // R2: a narrow write lands in its own lane of the wide word
            p_narrow_to_wide_r2: assert property (@(posedge n_clk) disable iff (n_rst || w_rst)
                ($past(n_wr) && w_en && !w_we && (w_row == $past(n_row)))
                |=> ((w_rdata & $past(n_bits, 2)) == ($past(n_wvec, 2) & $past(n_bits, 2))));
        end
    endgenerate

endmodule

// File: tb/asym_dpram_tb.sv
`timescale 1ns/1ps
module asym_dpram_tb;

    localparam int NDEPTH = 1024;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic        n_en, n_we, w_en, w_we;
    logic [9:0]  n_addr;
    logic [8:0]  w_addr;
    logic [12:0] n_wdata, n_rdata;
    logic [25:0] w_wdata, w_rdata;

    asym_dpram #(.SAME_CLK(1'b1)) u_dut (
        .n_clk(clk), .n_rst(rst), .n_en(n_en), .n_we(n_we), .n_addr(n_addr),
        .n_wdata(n_wdata), .n_rdata(n_rdata),
        .w_clk(clk), .w_rst(rst), .w_en(w_en), .w_we(w_we), .w_addr(w_addr),
        .w_wdata(w_wdata), .w_rdata(w_rdata));

    int total = 0;
    int bad   = 0;

    logic [12:0] refm [NDEPTH];

    typedef struct {
        logic [25:0] exp;
        string       tag;
    } item_t;

    item_t qn[$];
    item_t qw[$];
    logic [12:0] last_n;
    logic [25:0] last_w;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [25:0] act, input logic [25:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus on both ports, expectations pushed read-first.
    task automatic cyc(input bit ne, input bit nw, input int na, input logic [12:0] nd,
                       input bit we_, input bit ww, input int wa, input logic [25:0] wd,
                       input string tag);
        item_t it;
        @(negedge clk);
        n_en = ne; n_we = nw; n_addr = 10'(na); n_wdata = nd;
        w_en = we_; w_we = ww; w_addr = 9'(wa); w_wdata = wd;
        if (ne) begin
            it.exp = 26'(refm[na]); it.tag = tag; qn.push_back(it);
        end
        if (we_) begin
            it.exp = {refm[2*wa+1], refm[2*wa]}; it.tag = tag; qw.push_back(it);
        end
        if (ne && nw) refm[na] = nd;
        if (we_ && ww) begin
            refm[2*wa]   = wd[12:0];
            refm[2*wa+1] = wd[25:13];
        end
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(0, 0, 0, 13'h0, 0, 0, 0, 26'h0, "R7");
    endtask

    // Monitor: compare results one step after each active edge.
    initial begin
        last_n = '0;
        last_w = '0;
        forever begin
            bit sn, sw, sr;
            item_t it;
            @(posedge clk);
            sn = n_en; sw = w_en; sr = rst;
            #1;
            if (sr) begin
                last_n = '0;
                last_w = '0;
            end else begin
                if (sn) begin
                    if (qn.size() == 0) chk(0, "R5", "narrow read without expectation", 26'(n_rdata), 26'h0);
                    else begin
                        it = qn.pop_front();
                        chk(n_rdata == it.exp[12:0], it.tag, "narrow read data", 26'(n_rdata), 26'(it.exp[12:0]));
                    end
                end else begin
                    chk(n_rdata == last_n, "R7", "narrow hold while disabled", 26'(n_rdata), 26'(last_n));
                end
                if (sw) begin
                    if (qw.size() == 0) chk(0, "R5", "wide read without expectation", w_rdata, 26'h0);
                    else begin
                        it = qw.pop_front();
                        chk(w_rdata == it.exp, it.tag, "wide read data", w_rdata, it.exp);
                    end
                end else begin
                    chk(w_rdata == last_w, "R7", "wide hold while disabled", w_rdata, last_w);
                end
                last_n = n_rdata;
                last_w = w_rdata;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NDEPTH; i++) refm[i] = '0;
        rst = 1'b1;
        n_en = 0; n_we = 0; n_addr = '0; n_wdata = '0;
        w_en = 0; w_we = 0; w_addr = '0; w_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: read data cleared by reset
        chk(n_rdata == 13'h0, "R9", "narrow read data after reset", 26'(n_rdata), 26'h0);
        chk(w_rdata == 26'h0, "R9", "wide read data after reset", w_rdata, 26'h0);
        rst = 1'b0;

        // R9: store starts at zero
        cyc(1, 0, 5, 13'h0, 1, 0, 7, 26'h0, "R9");
        idle(1);

        // R3, R1: wide writes fill rows 0..7
        for (int i = 0; i < 8; i++)
            cyc(0, 0, 0, 13'h0, 1, 1, i, {13'(i*5 + 2), 13'(i*3 + 1)}, "R3");
        // R2: narrow reads of addresses 0..15 see low/high halves
        for (int i = 0; i < 16; i++)
            cyc(1, 0, i, 13'h0, 0, 0, 0, 26'h0, "R2");
        // R3: overwrite of a full row, read back wide
        cyc(0, 0, 0, 13'h0, 1, 1, 3, 26'h3FF_FC00, "R3");
        cyc(0, 0, 0, 13'h0, 1, 0, 3, 26'h0, "R3");

        // R4: narrow write to the high half of row 2 keeps the low half
        cyc(1, 1, 5, 13'h0ABC, 0, 0, 0, 26'h0, "R4");
        cyc(0, 0, 0, 13'h0, 1, 0, 2, 26'h0, "R4");
        cyc(1, 1, 6, 13'h1234, 0, 0, 0, 26'h0, "R4");
        cyc(0, 0, 0, 13'h0, 1, 0, 3, 26'h0, "R4");

        // R2, R1: narrow writes 32..47, wide reads rows 16..23
        for (int i = 32; i < 48; i++)
            cyc(1, 1, i, 13'(i*97 + 11), 0, 0, 0, 26'h0, "R1");
        for (int i = 16; i < 24; i++)
            cyc(0, 0, 0, 13'h0, 1, 0, i, 26'h0, "R2");

        // R6: same-port write with read returns the old value
        cyc(1, 1, 40, 13'h1F0F, 0, 0, 0, 26'h0, "R6");
        cyc(1, 0, 40, 13'h0, 0, 0, 0, 26'h0, "R6");
        cyc(0, 0, 0, 13'h0, 1, 1, 20, 26'h155_5555, "R6");
        cyc(0, 0, 0, 13'h0, 1, 0, 20, 26'h0, "R6");
        // R6: cross-port write and read of the same row in one cycle
        cyc(1, 1, 42, 13'h0777, 1, 0, 21, 26'h0, "R6");
        cyc(1, 0, 43, 13'h0, 1, 1, 22, 26'h2AA_AAAA, "R6");
        cyc(1, 0, 44, 13'h0, 1, 0, 21, 26'h0, "R6");
        cyc(1, 0, 42, 13'h0, 0, 0, 0, 26'h0, "R6");

        // R8: disabled ports ignore write enable and data
        cyc(0, 1, 10, 13'h1FFF, 0, 1, 5, 26'h3FF_FFFF, "R8");
        idle(2);
        cyc(1, 0, 10, 13'h0, 1, 0, 5, 26'h0, "R8");

        // R10: both ports write disjoint rows in the same cycle
        cyc(1, 1, 600, 13'h0C3C, 1, 1, 301, 26'h123_4567, "R10");
        cyc(1, 1, 605, 13'h1111, 1, 1, 300, 26'h0FE_DCBA, "R10");
        cyc(1, 0, 600, 13'h0, 1, 0, 301, 26'h0, "R10");
        cyc(1, 0, 601, 13'h0, 1, 0, 302, 26'h0, "R10");

        // R1, R5: rate conversion, narrow stream in, wide rows out two cycles later
        for (int i = 0; i < 68; i++) begin
            bit ne = (i < 64);
            bit we_ = (i >= 4);
            cyc(ne, ne, 128 + i, 13'(i*29 + 3), we_, 0, 64 + (i - 4) / 2, 26'h0, "R5");
        end

        // R2: extreme addresses
        cyc(1, 1, 1023, 13'h1ACE, 1, 1, 0, 26'h2BE_EF01, "R2");
        cyc(1, 1, 1022, 13'h0BAD, 0, 0, 0, 26'h0, "R2");
        cyc(1, 0, 1, 13'h0, 1, 0, 511, 26'h0, "R2");
        cyc(1, 0, 0, 13'h0, 0, 0, 0, 26'h0, "R2");

        // R9: reset mid-run clears read data but not the store
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        n_en = 0; w_en = 0;
        @(negedge clk);
        chk(n_rdata == 13'h0, "R9", "narrow read data after mid-run reset", 26'(n_rdata), 26'h0);
        chk(w_rdata == 26'h0, "R9", "wide read data after mid-run reset", w_rdata, 26'h0);
        rst = 1'b0;
        cyc(1, 0, 1023, 13'h0, 1, 0, 511, 26'h0, "R9");
        cyc(1, 0, 7, 13'h0, 1, 0, 2, 26'h0, "R9");
        idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule